// File: doc/BRIEF.md
# Floating-Point Result Sign Unit

This block holds the sign of the result while a sequential floating-point unit works through a multi-cycle instruction. When a new instruction is accepted, it sets a working sign from the sign of operand B, inverted for subtract-type instructions. In the same cycle it latches two per-instruction flags: subtract-type and negated-result. On later cycles the control state machine changes the working sign only through a 3-bit opcode that selects one of five small operations.

Every cycle, a fixup stage takes the working sign and applies two rules. A zero result of a subtraction gets its sign from the rounding mode. A negated multiply-add then has its sign inverted. A NaN result is exempt from both rules. The fixed-up sign is registered and presented on `res_sign` for the following cycle, where the result-class logic and the packing logic read it. The working sign itself never holds the fixups, so later opcodes act on the unfixed value.

Top module: `fp_rsign`

## Requirements
- R1: After reset, and until the first accepted instruction, `res_sign` is 0.
- R2: In a cycle with `start` high, the working sign becomes `sign_b XOR sub_in`. The `res_sign` of the next cycle is that value after the fixup rules.
- R3: `sub_in` and `neg_in` are latched only in a `start` cycle. In all later cycles the latched copies are used and the live inputs are ignored.
- R4: Opcode 001 inverts the working sign.
- R5: Opcode 010 XORs the working sign with the latched subtract flag.
- R6: Opcodes 011, 100 and 101 load the working sign with `sign_a`, `sign_b` and `sign_c`, in that order.
- R7: Opcodes 000, 110 and 111 leave the working sign unchanged.
- R8: In a `start` cycle the opcode is ignored.
- R9: When `zero_res` is high and `nan_res` is low, the pre-negation sign is 1 if `rmode` is 11 (toward minus infinity) and 0 otherwise. The other `rmode` values are 00 nearest, 01 toward zero and 10 toward plus infinity.
- R10: When the negate flag is set and `nan_res` is low, the sign is inverted after the zero rule.
- R11: When `nan_res` is high, `res_sign` equals the working sign, with no zero rule and no negation applied.
- R12: The fixups never change the stored working sign. A later cycle without `zero_res` shows the unfixed working sign again.
- R13: `res_sign` is registered. It reflects the inputs of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | First cycle of a new instruction |
| sign_a | input | 1 | Sign of operand A |
| sign_b | input | 1 | Sign of operand B |
| sign_c | input | 1 | Sign of operand C |
| sub_in | input | 1 | Instruction is subtract-type (sampled on start) |
| neg_in | input | 1 | Instruction negates its result (sampled on start) |
| rmode | input | 2 | Rounding mode: 00 nearest, 01 zero, 10 +inf, 11 -inf |
| zero_res | input | 1 | Result is an exact zero from a subtraction |
| nan_res | input | 1 | Result is a NaN |
| sop | input | 3 | Sign opcode from the control state machine |
| res_sign | output | 1 | Registered final result sign |

## Verification
In one cycle an opcode can change the working sign while the zero rule and the negation both act on the new value. That cycle can also be a `start` cycle that replaces the flags the fixups use. The random stimulus drives `start`, `sop`, `zero_res`, `nan_res` and the flags independently, so these collisions occur often. Directed cycles force zero-with-negate under every rounding mode, NaN-with-negate, and `start` together with a live opcode. A bench model applies the requirement order to each cycle: first start or opcode, then the zero rule, then negation, with a NaN bypass. The next cycle's `res_sign` is judged against that model.

// File: rtl/fp_rsign_pkg.sv
package fp_rsign_pkg;
  localparam int OP_W = 3;
  localparam int RM_W = 2;

  typedef enum logic [OP_W-1:0] {
    SOP_KEEP = 3'd0,
    SOP_INV  = 3'd1,
    SOP_XSUB = 3'd2,
    SOP_LDA  = 3'd3,
    SOP_LDB  = 3'd4,
    SOP_LDC  = 3'd5
  } sop_e;

  typedef enum logic [RM_W-1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_PINF = 2'd2,
    RM_MINF = 2'd3
  } rmode_e;
endpackage

// File: rtl/fp_rsign_rsync.sv
module fp_rsign_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_ok = chain_q[STAGES-1];
endmodule

// File: rtl/fp_rsign_alu.sv
module fp_rsign_alu
  import fp_rsign_pkg::*;
(
  input  logic            cur,
  input  logic            sub_flag,
  input  logic            sign_a,
  input  logic            sign_b,
  input  logic            sign_c,
  input  logic [OP_W-1:0] op,
  output logic            nxt
);
  sop_e op_e;

  always_comb begin
    op_e = sop_e'(op);
    case (op_e)
      SOP_INV:  nxt = ~cur;
      SOP_XSUB: nxt = cur ^ sub_flag;
      SOP_LDA:  nxt = sign_a;
      SOP_LDB:  nxt = sign_b;
      SOP_LDC:  nxt = sign_c;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/fp_rsign_fix.sv
module fp_rsign_fix
  import fp_rsign_pkg::*;
(
  input  logic            base,
  input  logic            zero_res,
  input  logic            nan_res,
  input  logic            neg_flag,
  input  logic [RM_W-1:0] rmode,
  output logic            fixed
);
  logic zsign;

  always_comb begin
    if (zero_res) zsign = (rmode_e'(rmode) == RM_MINF);
    else          zsign = base;
    if (nan_res)  fixed = base;
    else          fixed = zsign ^ neg_flag;
  end
endmodule

// File: rtl/fp_rsign.sv
module fp_rsign
  import fp_rsign_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            sign_a,
  input  logic            sign_b,
  input  logic            sign_c,
  input  logic            sub_in,
  input  logic            neg_in,
  input  logic [RM_W-1:0] rmode,
  input  logic            zero_res,
  input  logic            nan_res,
  input  logic [OP_W-1:0] sop,
  output logic            res_sign
);
  logic rst_ok;
  logic work_q, work_d, work_en;
  logic sub_q, neg_q, flag_en;
  logic sub_eff, neg_eff;
  logic alu_out, base, fix_out;

  fp_rsign_rsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  fp_rsign_alu u_alu (
    .cur      (work_q),
    .sub_flag (sub_q),
    .sign_a   (sign_a),
    .sign_b   (sign_b),
    .sign_c   (sign_c),
    .op       (sop),
    .nxt      (alu_out)
  );

  // Next-state logic: start wins over the opcode
  always_comb begin
    sub_eff = start ? sub_in : sub_q;
    neg_eff = start ? neg_in : neg_q;
    base    = start ? (sign_b ^ sub_in) : alu_out;
    work_d  = base;
    work_en = start | (sop != SOP_KEEP);
    flag_en = start;
  end

  fp_rsign_fix u_fix (
    .base     (base),
    .zero_res (zero_res),
    .nan_res  (nan_res),
    .neg_flag (neg_eff),
    .rmode    (rmode),
    .fixed    (fix_out)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      work_q <= 1'b0;
    end else if (work_en) begin
      work_q <= work_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      sub_q <= 1'b0;
      neg_q <= 1'b0;
    end else if (flag_en) begin
      sub_q <= sub_eff;
      neg_q <= neg_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      res_sign <= 1'b0;
    end else begin
      res_sign <= fix_out;
    end
  end
endmodule

// File: rtl/fp_rsign_chk.sv
module fp_rsign_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       start,
  input logic       sign_a,
  input logic       sign_b,
  input logic       sub_in,
  input logic       neg_in,
  input logic [1:0] rmode,
  input logic       zero_res,
  input logic       nan_res,
  input logic [2:0] sop,
  input logic       neg_q,
  input logic       res_sign
);
  // R2
  start_sign_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (start && !zero_res && !nan_res) |=>
      res_sign == ($past(sign_b) ^ $past(sub_in) ^ $past(neg_in)));

  // R9
  zero_rule_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (start && zero_res && !nan_res) |=>
      res_sign == (($past(rmode) == 2'd3) ^ $past(neg_in)));

  // R11
  nan_bypass_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (start && nan_res) |=> res_sign == ($past(sign_b) ^ $past(sub_in)));

  // R6
  load_a_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!start && sop == 3'd3 && !zero_res && !nan_res) |=>
      res_sign == ($past(sign_a) ^ $past(neg_q)));

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !start |=> $stable(neg_q));
endmodule

bind fp_rsign fp_rsign_chk u_chk (
  .clk      (clk),
  .rst_ok   (rst_ok),
  .start    (start),
  .sign_a   (sign_a),
  .sign_b   (sign_b),
  .sub_in   (sub_in),
  .neg_in   (neg_in),
  .rmode    (rmode),
  .zero_res (zero_res),
  .nan_res  (nan_res),
  .sop      (sop),
  .neg_q    (neg_q),
  .res_sign (res_sign)
);

// File: tb/fp_rsign_bench.sv
module fp_rsign_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, sign_a, sign_b, sign_c, sub_in, neg_in;
  logic [1:0] rmode;
  logic       zero_res, nan_res;
  logic [2:0] sop;
  logic       res_sign;

  int n_chk = 0;
  int n_err = 0;
  logic m_work = 1'b0, m_sub = 1'b0, m_neg = 1'b0;
  logic exp_sign = 1'b0;

  always #4 clk = ~clk;

  fp_rsign u_fp_rsign (
    .clk(clk), .rst_n(rst_n), .start(start), .sign_a(sign_a),
    .sign_b(sign_b), .sign_c(sign_c), .sub_in(sub_in), .neg_in(neg_in),
    .rmode(rmode), .zero_res(zero_res), .nan_res(nan_res), .sop(sop),
    .res_sign(res_sign)
  );

  function automatic logic alu_f(logic cur, logic sf, logic a, logic b,
                                 logic c, logic [2:0] op);
    case (op)
      3'd1: return ~cur;
      3'd2: return cur ^ sf;
      3'd3: return a;
      3'd4: return b;
      3'd5: return c;
      default: return cur;
    endcase
  endfunction

  function automatic logic fix_f(logic base, logic z, logic nan,
                                 logic [1:0] rm, logic ng);
    logic s;
    if (nan) return base;
    s = z ? (rm == 2'd3) : base;
    return s ^ ng;
  endfunction

  task automatic chk(string tag, logic act, logic expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: res_sign=%b expected=%b", tag, act, expv);
    end
  endtask

  function automatic string tag_f();
    if (nan_res)       return "R11";
    if (zero_res)      return m_neg ? "R10" : "R9";
    if (start)         return (sop != 3'd0) ? "R8" : "R2";
    case (sop)
      3'd1:    return "R4";
      3'd2:    return "R5";
      3'd3, 3'd4, 3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic drive(logic st, logic a, logic b, logic c, logic su,
                       logic ng, logic [1:0] rm, logic z, logic nn,
                       logic [2:0] op);
    @(negedge clk);
    start = st; sign_a = a; sign_b = b; sign_c = c; sub_in = su;
    neg_in = ng; rmode = rm; zero_res = z; nan_res = nn; sop = op;
  endtask

  // one cycle: model, edge, sample (R13: one register of latency)
  task automatic step(string tag_ovr);
    logic base, sf, nf;
    string tg;
    sf   = start ? sub_in : m_sub;
    nf   = start ? neg_in : m_neg;
    base = start ? (sign_b ^ sub_in)
                 : alu_f(m_work, m_sub, sign_a, sign_b, sign_c, sop);
    exp_sign = fix_f(base, zero_res, nan_res, rmode, nf);
    tg = (tag_ovr != "") ? tag_ovr : tag_f();
    if (start || sop != 3'd0) m_work = base;
    m_sub = sf; m_neg = nf;
    @(posedge clk); #1;
    chk(tg, res_sign, exp_sign);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: res_sign=%b expected=done", res_sign);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    drive(1, 1, 1, 1, 1, 1, 2'd3, 0, 0, 3'd1);
    repeat (3) @(posedge clk);
    #1 chk("R1", res_sign, 1'b0);
    drive(0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 3'd0);
    rst_n = 1'b1;
    repeat (4) step("R1");

    // R2 / R8: start with live opcode
    drive(1, 0, 1, 0, 0, 0, 2'd0, 0, 0, 3'd3); step("R8");
    // R12: zero fixup does not stick
    drive(0, 0, 0, 0, 0, 0, 2'd0, 1, 0, 3'd0); step("R12");
    drive(0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 3'd0); step("R12");
    // R3 / R5: latched subtract flag, live sub_in toggled
    drive(1, 0, 0, 0, 1, 0, 2'd0, 0, 0, 3'd0); step("R2");
    drive(0, 0, 0, 0, 0, 1, 2'd0, 0, 0, 3'd2); step("R3");
    drive(0, 0, 0, 0, 0, 1, 2'd0, 0, 0, 3'd2); step("R5");
    // R7: reserved codes
    drive(0, 1, 1, 1, 0, 0, 2'd0, 0, 0, 3'd6); step("R7");
    drive(0, 1, 1, 1, 0, 0, 2'd0, 0, 0, 3'd7); step("R7");
    // R9 / R10: zero in every rounding mode, with and without negate
    for (int ng = 0; ng < 2; ng++) begin
      for (int rm = 0; rm < 4; rm++) begin
        drive(1, 0, 1, 0, 1, ng[0], rm[1:0], 1, 0, 3'd0);
        step(ng != 0 ? "R10" : "R9");
      end
    end
    // R11: NaN with negate set
    drive(1, 0, 1, 1, 0, 1, 2'd3, 1, 1, 3'd0); step("R11");
    drive(0, 0, 0, 1, 0, 0, 2'd3, 1, 1, 3'd5); step("R11");
    // R6 / R4
    drive(0, 1, 0, 0, 0, 0, 2'd0, 0, 0, 3'd3); step("R6");
    drive(0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 3'd1); step("R4");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom();
      drive(r[3:0] == 4'd0, r[4], r[5], r[6], r[7], r[8], r[10:9],
            r[14:11] == 4'd0, r[18:15] == 4'd0,
            (r[21:19] > 3'd5 && r[22]) ? 3'd0 : r[21:19]);
      step("");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule